// File: doc/BRIEF.md
# Fuse and Lock Byte Software Access Controller

This block sits next to a small processor core and decides when software may read the configuration fuse byte, read the lock byte, or program lock bits. Software writes two enable bits into a control register. That write arms a short access period that the block measures in clock edges. A program-memory load issued early in that period returns fuse or lock data instead of the Flash word. A program-memory store issued a little later in the period programs lock bits from the R0 byte.

The fuse and lock bits live in internal registers that come out of reset erased. An erased bit reads as 1. A programmed bit reads as 0, and no software operation can return a bit to 1. If no store arrives, the armed state clears itself after a fixed number of edges. While the block is armed, rewrites of the control register are refused. A pending EEPROM write blocks arming, reads and programming.

Edge numbering: the clock edge that accepts the control write is edge 0, and edge k is the k-th rising edge after it.

Top module: `fl_access_ctl`

## Requirements
- R1: A control write with bit 0 and bit 3 of `ctl_wdata` both 1 arms the block, provided the block is not armed and `ee_busy` is low. After that edge `ctl_bits` reads 2'b11. A write that leaves either of those bits at 0 leaves `ctl_bits` at 2'b00.
- R2: A load sampled at edges 1 to 3 updates `rd_data` on that edge. With `zptr` = 0x0001 it returns the lock byte. With `zptr` = 0x0000 it returns the fuse low byte, which is erased and reads 0xFF. Any other `zptr` returns 0xFF.
- R3: A load that is not in the read window updates `rd_data` with the `flash_rdata` sampled on the same edge. A load is outside the window when it comes at edge 4 or later, when the block is not armed, or when `ee_busy` is high. Without a load, `rd_data` holds its value.
- R4: A store sampled at edges 1 to 4, with `ee_busy` low, programs each lock bit i (i = 0, 1) whose R0 bit i is 0. The same edge clears `ctl_bits` to 2'b00. `zptr` has no effect on this operation.
- R5: A store sampled at edge 5 or later leaves the lock bits unchanged and leaves `ctl_bits` at 2'b11.
- R6: When no store is accepted, `ctl_bits` stays 2'b11 after edges 0 to 5 and becomes 2'b00 after edge 6.
- R7: A control write that arrives while the block is armed, whatever its data, has no effect. The armed period keeps its original timing.
- R8: While `ee_busy` is high, a control write does not arm the block, a load returns `flash_rdata`, and a store leaves both the lock bits and `ctl_bits` unchanged.
- R9: Reset gives `ctl_bits` = 2'b00, `rd_data` = 0x00 and all lock bits erased, so the lock byte reads 0xFF. The lock byte is {6'b111111, LB2, LB1}, with LB2 in bit 1 and LB1 in bit 0. A lock bit can only move from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data: bit 0 is program enable, bit 3 is fuse/lock select |
| ld_issue | input | 1 | Program-memory load issued this cycle |
| st_issue | input | 1 | Program-memory store issued this cycle |
| zptr | input | 16 | Z pointer value |
| r0_data | input | 8 | R0 register byte |
| ee_busy | input | 1 | EEPROM write in progress |
| flash_rdata | input | 8 | Normal Flash read data |
| rd_data | output | 8 | Load result byte (registered) |
| ctl_bits | output | 2 | Current {select, enable} control bits |

## Verification
The bench targets the edges where each window closes. A load at edge 3 must return fuse or lock data, and a load at edge 4 must return Flash data. A store at edge 4 must program bits, and a store at edge 5 must not. A counter that is off by one would move one of these boundaries, and the block would then return or program the wrong byte. The auto-clear edge is checked both with and without a refused rewrite in the armed period, which catches a design that restarts its timer on the rewrite. The bench also checks that EEPROM-busy suppresses each operation separately, and that R0 ones never restore a programmed lock bit.

// File: rtl/fl_pkg.sv
// Shared constants and types for the fuse/lock access controller.
// Assumes an 8-bit control register whose enable and select bits sit at
// the positions named below.
package fl_pkg;
    localparam int CTL_EN_POS  = 0;   // program enable bit in control write
    localparam int CTL_SEL_POS = 3;   // fuse/lock select bit in control write

    localparam logic [15:0] Z_FUSE_LO = 16'h0000;
    localparam logic [15:0] Z_LOCK    = 16'h0001;

    // Source chosen for the next load result.
    typedef enum logic [1:0] {
        SRC_FLASH   = 2'd0,
        SRC_LOCK    = 2'd1,
        SRC_FUSE_LO = 2'd2,
        SRC_BLANK   = 2'd3
    } rd_src_e;
endpackage

// File: rtl/fl_arm_window.sv
// Arming state and edge counter. After an accepted control write it counts
// edges and flags loads and stores that land inside their windows. It clears
// on an accepted store or when the count reaches CLEAR_AGE.
// Assumes LOAD_WIN <= STORE_WIN < CLEAR_AGE.
module fl_arm_window
    import fl_pkg::*;
#(
    parameter int CTL_W     = 8,
    parameter int LOAD_WIN  = 3,
    parameter int STORE_WIN = 4,
    parameter int CLEAR_AGE = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             ee_busy,
    input  logic             ld_issue,
    input  logic             st_issue,
    output logic             armed,
    output logic             ld_hit,
    output logic             st_hit
);
    localparam int AGE_W = $clog2(CLEAR_AGE + 1);
    localparam logic [AGE_W-1:0] LD_LAST  = AGE_W'(LOAD_WIN);
    localparam logic [AGE_W-1:0] ST_LAST  = AGE_W'(STORE_WIN);
    localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(CLEAR_AGE);

    logic [AGE_W-1:0] age_q;
    logic             arm_req;
    logic             unused_ctl;

    assign unused_ctl = ^ctl_wdata;

    // Decide whether this edge may arm the block.
    always_comb begin
        arm_req = ctl_wr && !ee_busy && ctl_wdata[CTL_EN_POS] && ctl_wdata[CTL_SEL_POS];
    end

    // Flag loads and stores that fall inside their windows.
    always_comb begin
        ld_hit = armed && !ee_busy && ld_issue && (age_q <= LD_LAST);
        st_hit = armed && !ee_busy && st_issue && (age_q <= ST_LAST);
    end

    // Track the armed state and the edge count since arming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            age_q <= '0;
        end else if (!armed) begin
            if (arm_req) begin
                armed <= 1'b1;
                age_q <= AGE_W'(1);
            end
        end else if (st_hit || age_q == AGE_LAST) begin
            armed <= 1'b0;
            age_q <= '0;
        end else begin
            age_q <= age_q + AGE_W'(1);
        end
    end
endmodule

// File: rtl/fl_lock_store.sv
// Lock bit storage. The bits come out of reset erased (1). An accepted store
// programs each bit whose matching R0 bit is 0, and nothing sets a bit back.
module fl_lock_store #(
    parameter int LOCK_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 st_hit,
    input  logic [LOCK_BITS-1:0] r0_bits,
    output logic [LOCK_BITS-1:0] lock_q
);
    for (genvar i = 0; i < LOCK_BITS; i++) begin : g_bit
        // Per-bit one-way programming cell.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lock_q[i] <= 1'b1;
            end else if (st_hit && !r0_bits[i]) begin
                lock_q[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/fl_read_path.sv
// Load result register. On every load it captures either the Flash byte or
// a fuse/lock byte chosen by the Z pointer. Between loads it holds.
// Assumes LOCK_BITS < DATA_W; the upper lock byte bits read 1.
module fl_read_path
    import fl_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 16,
    parameter int LOCK_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_issue,
    input  logic                 ld_hit,
    input  logic [ADDR_W-1:0]    zptr,
    input  logic [LOCK_BITS-1:0] lock_q,
    input  logic [DATA_W-1:0]    fuse_lo,
    input  logic [DATA_W-1:0]    flash_rdata,
    output logic [DATA_W-1:0]    rd_data
);
    rd_src_e           src;
    logic [DATA_W-1:0] lock_byte;
    logic [DATA_W-1:0] next_byte;

    // Build the lock byte with unused upper bits read as erased.
    always_comb begin
        lock_byte = '1;
        lock_byte[LOCK_BITS-1:0] = lock_q;
    end

    // Choose the load source from the window flag and the pointer.
    always_comb begin
        if (!ld_hit)                             src = SRC_FLASH;
        else if (zptr == ADDR_W'(Z_LOCK))        src = SRC_LOCK;
        else if (zptr == ADDR_W'(Z_FUSE_LO))     src = SRC_FUSE_LO;
        else                                     src = SRC_BLANK;
    end

    // Map the source to a data byte.
    always_comb begin
        unique case (src)
            SRC_FLASH:   next_byte = flash_rdata;
            SRC_LOCK:    next_byte = lock_byte;
            SRC_FUSE_LO: next_byte = fuse_lo;
            default:     next_byte = '1;
        endcase
    end

    // Capture the result on a load, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)        rd_data <= '0;
        else if (ld_issue) rd_data <= next_byte;
    end
endmodule

// File: rtl/fl_access_ctl.sv
// Top of the fuse/lock access controller. It joins the arming window, the
// lock storage and the read path. The fuse low byte is held erased because
// no software path programs it.
// Assumes one instruction strobe per cycle at most.
module fl_access_ctl #(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 16,
    parameter int LOCK_BITS = 2,
    parameter int LOAD_WIN  = 3,
    parameter int STORE_WIN = 4,
    parameter int CLEAR_AGE = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] ctl_wdata,
    input  logic              ld_issue,
    input  logic              st_issue,
    input  logic [ADDR_W-1:0] zptr,
    input  logic [DATA_W-1:0] r0_data,
    input  logic              ee_busy,
    input  logic [DATA_W-1:0] flash_rdata,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        ctl_bits
);
    logic                 armed;
    logic                 ld_hit;
    logic                 st_hit;
    logic [LOCK_BITS-1:0] lock_q;
    logic [DATA_W-1:0]    fuse_lo;
    logic                 unused_r0;

    assign unused_r0 = ^r0_data;
    assign ctl_bits  = {armed, armed};

    // Fuse low byte cell: erased at reset, no software write path.
    always_ff @(posedge clk) begin
        if (!rst_n) fuse_lo <= '1;
    end

    fl_arm_window #(
        .CTL_W(DATA_W), .LOAD_WIN(LOAD_WIN),
        .STORE_WIN(STORE_WIN), .CLEAR_AGE(CLEAR_AGE)
    ) u_win (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ee_busy(ee_busy), .ld_issue(ld_issue), .st_issue(st_issue),
        .armed(armed), .ld_hit(ld_hit), .st_hit(st_hit)
    );

    fl_lock_store #(.LOCK_BITS(LOCK_BITS)) u_lock (
        .clk(clk), .rst_n(rst_n), .st_hit(st_hit),
        .r0_bits(r0_data[LOCK_BITS-1:0]), .lock_q(lock_q)
    );

    fl_read_path #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LOCK_BITS(LOCK_BITS)
    ) u_rd (
        .clk(clk), .rst_n(rst_n), .ld_issue(ld_issue), .ld_hit(ld_hit),
        .zptr(zptr), .lock_q(lock_q), .fuse_lo(fuse_lo),
        .flash_rdata(flash_rdata), .rd_data(rd_data)
    );
endmodule

// File: rtl/fl_access_checker.sv
// Property checker for fl_access_ctl. It keeps its own count of edges spent
// armed and checks window closure, interlocks and one-way lock bits.
module fl_access_checker #(
    parameter int DATA_W    = 8,
    parameter int LOCK_BITS = 2,
    parameter int STORE_WIN = 4,
    parameter int CLEAR_AGE = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ctl_wr,
    input logic                 ld_issue,
    input logic                 st_issue,
    input logic                 ee_busy,
    input logic [DATA_W-1:0]    flash_rdata,
    input logic [DATA_W-1:0]    rd_data,
    input logic                 armed,
    input logic [LOCK_BITS-1:0] lock_q
);
    int unsigned cnt;

    // Count edges since the armed state began.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= 0;
        else        cnt <= armed ? cnt + 1 : 0;
    end

    a_r6_clear_by_age: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (cnt < CLEAR_AGE));

    a_r7_rewrite_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ctl_wr && !st_issue && cnt < CLEAR_AGE - 1) |=> armed);

    a_r4_store_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && st_issue && !ee_busy && cnt < STORE_WIN) |=> !armed);

    a_r8_busy_blocks_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_busy && !armed) |=> !armed);

    a_r3_flash_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_issue && !armed) |=> (rd_data == $past(flash_rdata)));

    a_r9_lock_one_way: assert property (@(posedge clk) disable iff (!rst_n)
        ((lock_q & ~$past(lock_q)) == '0));
endmodule

bind fl_access_ctl fl_access_checker #(
    .DATA_W(DATA_W), .LOCK_BITS(LOCK_BITS),
    .STORE_WIN(STORE_WIN), .CLEAR_AGE(CLEAR_AGE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ld_issue(ld_issue),
    .st_issue(st_issue), .ee_busy(ee_busy), .flash_rdata(flash_rdata),
    .rd_data(rd_data), .armed(armed), .lock_q(lock_q)
);

// File: tb/tb_fl_access_ctl.sv
module tb_fl_access_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [7:0]  ctl_wdata = 8'h00;
    logic        ld_issue = 1'b0;
    logic        st_issue = 1'b0;
    logic [15:0] zptr = 16'h0000;
    logic [7:0]  r0_data = 8'hFF;
    logic        ee_busy = 1'b0;
    logic [7:0]  flash_rdata = 8'h00;
    logic [7:0]  rd_data;
    logic [1:0]  ctl_bits;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // Behavioural reference state.
    int m_armed = 0, m_age = 0, m_lock = 3, m_rd = 0;

    fl_access_ctl dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ld_issue(ld_issue), .st_issue(st_issue), .zptr(zptr),
        .r0_data(r0_data), .ee_busy(ee_busy), .flash_rdata(flash_rdata),
        .rd_data(rd_data), .ctl_bits(ctl_bits)
    );

    always #5 clk = ~clk;

    // Reference model: advance on each rising edge from the inputs.
    always @(posedge clk) begin
        int ld_ok, st_ok;
        if (!rst_n) begin
            m_armed = 0; m_age = 0; m_lock = 3; m_rd = 0;
        end else begin
            ld_ok = (m_armed != 0 && !ee_busy && ld_issue && m_age <= 3);
            st_ok = (m_armed != 0 && !ee_busy && st_issue && m_age <= 4);
            if (ld_issue) begin
                if (!ld_ok)             m_rd = flash_rdata;
                else if (zptr == 16'd1) m_rd = 8'hFC | m_lock;
                else                    m_rd = 8'hFF;
            end
            if (st_ok) m_lock = m_lock & r0_data[1:0];
            if (m_armed == 0) begin
                if (ctl_wr && !ee_busy && ctl_wdata[0] && ctl_wdata[3]) begin
                    m_armed = 1; m_age = 1;
                end
            end else if (st_ok || m_age == 6) begin
                m_armed = 0; m_age = 0;
            end else begin
                m_age = m_age + 1;
            end
        end
    end

    // Compare against the model every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_tests++;
            if (rd_data !== 8'(m_rd)) begin
                n_fail++;
                $display("FAIL R2,R3 model rd_data actual=%h expected=%h", rd_data, 8'(m_rd));
            end
            n_tests++;
            if (ctl_bits !== (m_armed != 0 ? 2'b11 : 2'b00)) begin
                n_fail++;
                $display("FAIL R1,R6 model ctl_bits actual=%b expected=%b",
                         ctl_bits, (m_armed != 0 ? 2'b11 : 2'b00));
            end
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        ctl_wr = 0; ld_issue = 0; st_issue = 0; ee_busy = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) step();
    endtask

    task automatic wr(input logic [7:0] d);
        ctl_wr = 1; ctl_wdata = d; step();
    endtask

    task automatic arm();
        wr(8'h09);
    endtask

    task automatic load(input logic [15:0] z, input logic [7:0] fl);
        ld_issue = 1; zptr = z; flash_rdata = fl; step();
    endtask

    task automatic store(input logic [7:0] r0, input logic [15:0] z);
        st_issue = 1; r0_data = r0; zptr = z; step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R9 reset ctl_bits", {6'b0, ctl_bits}, 8'h00);
        chk("R9 reset rd_data", rd_data, 8'h00);

        load(16'h0001, 8'h5A);
        chk("R3 unarmed load", rd_data, 8'h5A);
        wr(8'h01);
        chk("R1 enable only", {6'b0, ctl_bits}, 8'h00);
        wr(8'h08);
        chk("R1 select only", {6'b0, ctl_bits}, 8'h00);

        arm();
        chk("R1 armed", {6'b0, ctl_bits}, 8'h03);
        load(16'h0001, 8'h11);
        chk("R2 lock read edge1 erased", rd_data, 8'hFF);
        idle(4);
        chk("R6 still armed after edge5", {6'b0, ctl_bits}, 8'h03);
        idle(1);
        chk("R6 cleared after edge6", {6'b0, ctl_bits}, 8'h00);

        arm(); idle(2);
        load(16'h0000, 8'h22);
        chk("R2 fuse read edge3", rd_data, 8'hFF);
        idle(4);

        arm(); idle(3);
        load(16'h0001, 8'hA5);
        chk("R3 load edge4 outside window", rd_data, 8'hA5);
        idle(3);

        arm();
        load(16'h0002, 8'h77);
        chk("R2 other pointer", rd_data, 8'hFF);
        idle(6);

        arm(); idle(3);
        store(8'hFE, 16'h1234);
        chk("R4 store edge4 disarms", {6'b0, ctl_bits}, 8'h00);
        arm();
        load(16'h0001, 8'h00);
        chk("R4 LB1 programmed", rd_data, 8'hFE);
        idle(6);

        arm(); idle(4);
        store(8'hFD, 16'h0001);
        chk("R5 late store keeps armed", {6'b0, ctl_bits}, 8'h03);
        idle(2);
        arm();
        load(16'h0001, 8'h00);
        chk("R5 late store no effect", rd_data, 8'hFE);
        idle(6);

        arm();
        wr(8'h00);
        chk("R7 rewrite ignored", {6'b0, ctl_bits}, 8'h03);
        wr(8'h09);
        idle(3);
        chk("R7 timing kept after edge5", {6'b0, ctl_bits}, 8'h03);
        idle(1);
        chk("R6 R7 cleared after edge6", {6'b0, ctl_bits}, 8'h00);

        ee_busy = 1; wr(8'h09);
        chk("R8 busy blocks arm", {6'b0, ctl_bits}, 8'h00);
        arm();
        ee_busy = 1; load(16'h0001, 8'h3C);
        chk("R8 busy load gives flash", rd_data, 8'h3C);
        ee_busy = 1; store(8'h00, 16'h0001);
        chk("R8 busy store keeps armed", {6'b0, ctl_bits}, 8'h03);
        idle(4);
        arm();
        load(16'h0001, 8'h00);
        chk("R8 busy store no effect", rd_data, 8'hFE);
        idle(6);

        arm();
        store(8'hFF, 16'h0001);
        arm();
        load(16'h0001, 8'h00);
        chk("R9 ones do not erase", rd_data, 8'hFE);
        idle(6);
        arm();
        store(8'hFD, 16'h0000);
        arm();
        load(16'h0001, 8'h00);
        chk("R4 LB2 programmed", rd_data, 8'hFC);
        idle(6);
        arm();
        store(8'hFF, 16'h0000);
        arm();
        load(16'h0001, 8'h00);
        chk("R9 bits stay programmed", rd_data, 8'hFC);
        idle(3);
        chk("R3 rd_data holds", rd_data, 8'hFC);
        idle(4);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule